// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave-side protocol engine of a 256-byte serial memory on a two-wire bus. It samples the SCL and SDA lines against a fast system clock, detects start and stop conditions, takes in a device address byte and compares it with its strap inputs, and answers with an open-drain acknowledge. Once it has been addressed, it either receives a word address and data bytes, or it shifts data bytes out to the host.

A single 8-bit pointer serves both directions. A write sets the pointer from the word address and then stores each following data byte at the pointer. A read returns the byte at the pointer. Each byte that moves advances the pointer. The memory array sits outside the block and is reached through a one-cycle-latency read and write port. A busy input from the external write sequencer stops the block from answering its address while an internal write cycle is running. The host can therefore poll for completion.

The system clock must run at least 8 times the SCL rate. Both bus lines pass through synchronizers before the block detects edges on them.

Top module: `twsm_slave`

## Requirements
- R1: Until a start condition (SDA falling while SCL is high) is seen, the block drives nothing and touches no memory. A stop condition (SDA rising while SCL is high) returns it to idle with SDA released.
- R2: An address byte is accepted only if bits 7:4 equal 1010 and bits 3:1 equal `strap_i[2:0]`. Bit 0 selects the direction: 1 is read, 0 is write. Any other address byte gets no acknowledge and sends the block back to idle.
- R3: After each byte the block accepts, it pulls SDA low (`sda_pull_n_o` = 0) for the whole ninth SCL clock.
- R4: In a write, the first byte after the address sets the pointer. Each later byte produces exactly one `mem_wr_o` pulse, carrying that byte at the current pointer.
- R5: After a written byte the pointer advances within its 16-byte page: bits 3:0 increment and wrap, and bits 7:4 stay fixed.
- R6: A read with no preceding word address (current-address read) returns the byte at the pointer, which is the location after the last one accessed. Location 255 is followed by location 0.
- R7: In a read, each master acknowledge brings out the next byte. The read pointer wraps from 255 to 0. A master no-acknowledge ends the transfer, and the next current-address read continues at the following location.
- R8: A write-addressed byte followed by a word address, a repeated start and a read-addressed byte returns data from the new word address.
- R9: While `busy_i` is high, the block does not acknowledge its address byte. Once `busy_i` is low, the same address byte is acknowledged.
- R10: A start condition seen at any point abandons the current transfer. A partly received data byte is not written, and the block begins a new address reception.
- R11: `sda_pull_n_o` changes only while SCL is low. It is released (1) during the host's acknowledge slot of a read.
- R12: `mem_rd_o` and `mem_wr_o` are single-cycle pulses and are never high together. Read data is taken on `mem_rdata_i` in the cycle after `mem_rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap_i | input | 3 | Device select straps compared with address bits 3:1 |
| busy_i | input | 1 | Internal write cycle in progress; suppresses address acknowledge |
| sda_pull_n_o | output | 1 | Active-low SDA drive: 0 pulls the line low, 1 releases it |
| mem_addr_o | output | 8 | Array address for read or write |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to store |
| mem_rdata_i | input | 8 | Byte read, valid the cycle after `mem_rd_o` |

## Verification
A table of address and data pairs drives byte writes, each read back with a random read. The pairs cover both halves of the array, both ends of a page and all-zero and all-one bytes, so that a wrong store address, a lost bit or a bit-order fault shows as a mismatch. Directed sequences then separate the two pointer wrap modes: a three-byte write across a page end is compared with a sequential read across location 255, and a current-address read afterwards shows where each mode left the pointer. Rejected address bytes (wrong straps, wrong type code, busy, no start) are each followed by an accepted transfer, which shows that the rejection left no state behind. An aborted data byte is followed by a read of the same location.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twsm_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WORD,
    K_DATA
  } twsm_kind_e;
endpackage

// File: rtl/twsm_line_sync.sv
module twsm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      scl_p     <= scl_ff[STAGES-1];
      sda_p     <= sda_ff[STAGES-1];
    end
  end

  // remaining synchronizer stages
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else begin
        scl_ff[g] <= scl_ff[g-1];
        sda_ff[g] <= sda_ff[g-1];
      end
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/twsm_ptr.sv
module twsm_ptr #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_wr_i,
  input  logic          inc_rd_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] wr_next;
  logic [AW-1:0] rd_next;

  assign rd_next = ptr_q + AW'(1);

  // write increment stays inside the page
  if (PAGE_BITS >= AW) begin : g_flat
    assign wr_next = rd_next;
  end else begin : g_paged
    logic [PAGE_BITS-1:0] low_next;
    assign low_next = ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1);
    assign wr_next  = {ptr_q[AW-1:PAGE_BITS], low_next};
  end

  always_ff @(posedge clk) begin
    if (rst)           ptr_q <= '0;
    else if (load_i)   ptr_q <= load_val_i;
    else if (inc_wr_i) ptr_q <= wr_next;
    else if (inc_rd_i) ptr_q <= rd_next;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/twsm_fsm.sv
module twsm_fsm
  import twsm_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          STRAP_W  = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [AW-1:0]      ptr_i,
  output logic               ptr_load_o,
  output logic [AW-1:0]      ptr_val_o,
  output logic               inc_wr_o,
  output logic               inc_rd_o,
  output logic               pull_n_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i
);
  twsm_state_e       state;
  twsm_kind_e        kind;
  logic [2:0]        bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              is_read;
  logic              host_ack;
  logic              fetch_req;
  logic              rd_q;
  logic              addr_hit;

  assign addr_hit  = (rx_sh[7:4] == DEV_CODE) &&
                     (rx_sh[STRAP_W:1] == strap_i) && !busy_i;
  assign ptr_val_o = rx_sh[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      kind        <= K_DEV;
      bit_cnt     <= '0;
      byte_done   <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      is_read     <= 1'b0;
      host_ack    <= 1'b0;
      fetch_req   <= 1'b0;
      rd_q        <= 1'b0;
      pull_n_o    <= 1'b1;
      ptr_load_o  <= 1'b0;
      inc_wr_o    <= 1'b0;
      inc_rd_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
    end else begin
      mem_rd_o   <= 1'b0;
      mem_wr_o   <= 1'b0;
      ptr_load_o <= 1'b0;
      inc_wr_o   <= 1'b0;
      inc_rd_o   <= 1'b0;
      fetch_req  <= 1'b0;
      rd_q       <= mem_rd_o;
      // prefetch the next byte once the read pointer has moved
      if (inc_rd_o) fetch_req <= 1'b1;
      if (fetch_req) begin
        mem_rd_o   <= 1'b1;
        mem_addr_o <= ptr_i;
      end
      if (rd_q) tx_sh <= mem_rdata_i;

      if (stop_i) begin
        state    <= ST_IDLE;
        pull_n_o <= 1'b1;
      end else if (start_i) begin
        state     <= ST_RX;
        kind      <= K_DEV;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        pull_n_o  <= 1'b1;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_i && !byte_done) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall_i && byte_done) begin
              byte_done <= 1'b0;
              bit_cnt   <= '0;
              unique case (kind)
                K_DEV: begin
                  if (addr_hit) begin
                    pull_n_o <= 1'b0;
                    state    <= ST_ACK;
                    is_read  <= rx_sh[0];
                    if (rx_sh[0]) fetch_req <= 1'b1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_WORD: begin
                  ptr_load_o <= 1'b1;
                  pull_n_o   <= 1'b0;
                  state      <= ST_ACK;
                end
                default: begin
                  mem_wr_o    <= 1'b1;
                  mem_addr_o  <= ptr_i;
                  mem_wdata_o <= rx_sh;
                  inc_wr_o    <= 1'b1;
                  pull_n_o    <= 1'b0;
                  state       <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (is_read) begin
                pull_n_o <= tx_sh[7];
                bit_cnt  <= '0;
                state    <= ST_TX;
              end else begin
                pull_n_o <= 1'b1;
                state    <= ST_RX;
                kind     <= (kind == K_DEV) ? K_WORD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt == 3'd7) begin
                pull_n_o <= 1'b1;
                inc_rd_o <= 1'b1;
                state    <= ST_MACK;
              end else begin
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                pull_n_o <= tx_sh[6];
                bit_cnt  <= bit_cnt + 3'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              host_ack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (host_ack) begin
                pull_n_o <= tx_sh[7];
                bit_cnt  <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave #(
  parameter int         AW        = 8,
  parameter int         PAGE_BITS = 4,
  parameter int         STRAP_W   = 3,
  parameter int         SYNC_LEN  = 2,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               sda_pull_n_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i
);
  logic scl_w, sda_w, rise_w, fall_w, start_w, stop_w;
  logic ptr_load_w, inc_wr_w, inc_rd_w;
  logic [AW-1:0] ptr_w, ptr_val_w;

  twsm_line_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_w), .sda_o(sda_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  twsm_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst(rst), .load_i(ptr_load_w), .load_val_i(ptr_val_w),
    .inc_wr_i(inc_wr_w), .inc_rd_i(inc_rd_w), .ptr_o(ptr_w)
  );

  twsm_fsm #(.AW(AW), .STRAP_W(STRAP_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk(clk), .rst(rst), .sda_i(sda_w), .scl_rise_i(rise_w),
    .scl_fall_i(fall_w), .start_i(start_w), .stop_i(stop_w),
    .strap_i(strap_i), .busy_i(busy_i), .ptr_i(ptr_w),
    .ptr_load_o(ptr_load_w), .ptr_val_o(ptr_val_w),
    .inc_wr_o(inc_wr_w), .inc_rd_o(inc_rd_w), .pull_n_o(sda_pull_n_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  logic unused_w;
  assign unused_w = scl_w;
endmodule

// File: rtl/twsm_slave_chk.sv
module twsm_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic pull_n,
  input logic mem_rd,
  input logic mem_wr,
  input logic start_ev,
  input logic stop_ev
);
  p_rw_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  p_wr_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);
  p_rd_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull_n) |-> !scl_i);
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> pull_n);
  p_start_release_r10: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> pull_n);
endmodule

bind twsm_slave twsm_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .pull_n(sda_pull_n_o),
  .mem_rd(mem_rd_o), .mem_wr(mem_wr_o),
  .start_ev(start_w), .stop_ev(stop_w)
);

// File: tb/twsm_slave_tb_top.sv
`timescale 1ns/1ps
module twsm_slave_tb_top;
  localparam int HALF = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  // {word address, data}
  localparam logic [15:0] VEC [6] = '{16'h003C, 16'h7FA5, 16'h8001,
                                      16'hFFFE, 16'h1000, 16'h33FF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic [2:0] strap = STRAP;
  logic pull_n, mem_rd, mem_wr;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_line;
  int n_chk = 0;
  int n_bad = 0;
  int r12_bad = 0;
  int wr_cnt = 0;
  logic wr_prev = 1'b0;
  logic rd_prev = 1'b0;
  logic [7:0] mem_model [256];
  logic [7:0] ref_mem [256];

  always #2 clk = ~clk;
  assign sda_line = sda_m & pull_n;

  twsm_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .sda_pull_n_o(pull_n), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_wr) mem_model[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem_model[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && mem_wr) r12_bad++;
      if (mem_wr && wr_prev) r12_bad++;
      if (mem_rd && rd_prev) r12_bad++;
      if (mem_wr) wr_cnt++;
    end
    wr_prev <= mem_wr;
    rd_prev <= mem_rd;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1;   wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl = 1'b0;   wt(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl = 1'b1;   wt(HALF);
    sda_m = 1'b1; wt(HALF * 2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;  wt(HALF);
    scl = 1'b1; wt(HALF);
    scl = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1;   wt(HALF / 2);
    ack = ~sda_line;
    wt(HALF / 2);
    scl = 1'b0;
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF);
      scl = 1'b1; wt(HALF / 2);
      b[i] = sda_line;
      wt(HALF / 2);
      scl = 1'b0;
    end
    sda_m = ~give_ack; wt(HALF);
    scl = 1'b1; wt(HALF / 2);
    chk("R11 slave released in host ack slot", {31'd0, pull_n}, 32'd1);
    wt(HALF / 2);
    scl = 1'b0;
  endtask

  task automatic wr_txn(input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    tx_byte(DEV_W, k0); tx_byte(a, k1); tx_byte(d, k2);
    bus_stop();
    ok = k0 & k1 & k2;
    ref_mem[a] = d;
  endtask

  task automatic rd_random(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    tx_byte(DEV_W, k0); tx_byte(a, k1);
    bus_start();
    tx_byte(DEV_R, k2);
    rx_byte(1'b0, d);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic rd_current(output logic [7:0] d, output logic ok);
    bus_start();
    tx_byte(DEV_R, ok);
    rx_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_model[i] = 8'(i * 7 + 3);
      ref_mem[i]   = 8'(i * 7 + 3);
    end
  end

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic ok, k;
    logic [7:0] d;
    int wr_before;
    wt(5);
    rst = 1'b0;
    wt(2);
    // R1: reset state
    chk("R1 reset pull released", {31'd0, pull_n}, 32'd1);
    chk("R12 reset strobes low", {30'd0, mem_rd, mem_wr}, 32'd0);

    // R1: bits with no start are ignored
    tx_byte(DEV_W, k);
    chk("R1 no ack before start", {31'd0, k}, 32'd0);
    bus_stop();

    // R2: wrong straps and wrong type code
    bus_start(); tx_byte(8'hA0, k); bus_stop();
    chk("R2 strap mismatch not acked", {31'd0, k}, 32'd0);
    bus_start(); tx_byte(8'h6A, k); bus_stop();
    chk("R2 type code mismatch not acked", {31'd0, k}, 32'd0);
    bus_start(); tx_byte(DEV_W, k); bus_stop();
    chk("R3 matching address acked", {31'd0, k}, 32'd1);

    // R4 / R8: table of writes, each read back at random
    for (int v = 0; v < 6; v++) begin
      wr_before = wr_cnt;
      wr_txn(VEC[v][15:8], VEC[v][7:0], ok);
      chk("R3 write bytes acked", {31'd0, ok}, 32'd1);
      chk("R4 one write strobe per byte", wr_cnt - wr_before, 32'd1);
      rd_random(VEC[v][15:8], d, ok);
      chk("R8 random read acked", {31'd0, ok}, 32'd1);
      chk("R8 random read data", {24'd0, d}, {24'd0, ref_mem[VEC[v][15:8]]});
    end

    // R6: current read after location 255 gives location 0
    rd_random(8'hFF, d, ok);
    rd_current(d, ok);
    chk("R6 current read wraps to 0", {24'd0, d}, {24'd0, ref_mem[0]});
    rd_current(d, ok);
    chk("R6 current read next location", {24'd0, d}, {24'd0, ref_mem[1]});

    // R7: sequential read across 255
    bus_start();
    tx_byte(DEV_W, k); tx_byte(8'hFE, k);
    bus_start();
    tx_byte(DEV_R, k);
    rx_byte(1'b1, d); chk("R7 seq byte FE", {24'd0, d}, {24'd0, ref_mem[8'hFE]});
    rx_byte(1'b1, d); chk("R7 seq byte FF", {24'd0, d}, {24'd0, ref_mem[8'hFF]});
    rx_byte(1'b0, d); chk("R7 seq wrap to 00", {24'd0, d}, {24'd0, ref_mem[8'h00]});
    bus_stop();
    rd_current(d, ok);
    chk("R7 after nack pointer at 01", {24'd0, d}, {24'd0, ref_mem[8'h01]});

    // R5: three bytes from 2E wrap inside the page
    bus_start();
    tx_byte(DEV_W, k); tx_byte(8'h2E, k);
    tx_byte(8'hC1, k); tx_byte(8'hC2, k); tx_byte(8'hC3, k);
    bus_stop();
    ref_mem[8'h2E] = 8'hC1; ref_mem[8'h2F] = 8'hC2; ref_mem[8'h20] = 8'hC3;
    rd_random(8'h20, d, ok);
    chk("R5 page wrap lands at 20", {24'd0, d}, 32'h0000_00C3);
    rd_random(8'h30, d, ok);
    chk("R5 next page untouched", {24'd0, d}, {24'd0, ref_mem[8'h30]});
    rd_random(8'h2F, d, ok);
    chk("R5 byte at 2F", {24'd0, d}, 32'h0000_00C2);

    // R9: busy suppresses address ack, polling then succeeds
    busy = 1'b1;
    bus_start(); tx_byte(DEV_W, k); bus_stop();
    chk("R9 no ack while busy", {31'd0, k}, 32'd0);
    busy = 1'b0;
    bus_start(); tx_byte(DEV_W, k); bus_stop();
    chk("R9 ack after busy clears", {31'd0, k}, 32'd1);

    // R10: start in the middle of a data byte
    wr_before = wr_cnt;
    bus_start();
    tx_byte(DEV_W, k); tx_byte(8'h50, k);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    tx_byte(DEV_W, k);
    chk("R10 address after abort acked", {31'd0, k}, 32'd1);
    bus_stop();
    chk("R10 aborted byte not written", wr_cnt - wr_before, 32'd0);
    rd_random(8'h50, d, ok);
    chk("R10 location keeps old data", {24'd0, d}, {24'd0, ref_mem[8'h50]});

    chk("R12 strobe pulses clean", r12_bad, 32'd0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule